// File: doc/BRIEF.md
# Dual-Payload Video Line Packer

This block builds the byte-serial "superframe" video stream for a 640 x 480 sensor. Each output line holds two payloads in sequence. The first is a 4:2:2 YCbCr section: one luma byte for every pixel, plus one Cb byte and one Cr byte for every pair of pixels. Each chroma byte is the rounded mean of the two pixels in its pair. The second payload is the raw 14-bit pre-gain word of every pixel on the same line. Each raw word is widened to 16 bits and sent as two bytes. The bytes appear on a 14-bit parallel bus with a line-sync qualifier and a frame-sync qualifier.

The packer does not store pixels. It drives a line index and a column address, and the caller returns pixel data in the same cycle. Colour data comes back through two pixel ports (the even and odd pixel of the addressed pair). The raw word comes back through a single port. The caller supplies raw words taken from the frame before the one whose colour data is being sent. The colour conversion and the frame store belong to the caller.

The sequencer cycles through seven states. IDLE is held during reset and always moves to FRONT. FRONT raises frame sync and moves to CSEC after FRONT_CYC cycles. CSEC is the colour section and moves to RSEC after 2*PIXELS transfers. RSEC is the raw section. After 2*PIXELS transfers it moves to HGAP, or to BACK if the line was the last of the frame. HGAP moves to CSEC after HGAP_CYC cycles. BACK keeps frame sync high for BACK_CYC cycles and then moves to VGAP. VGAP holds frame sync low for VGAP_CYC cycles and then moves to FRONT.

Top module: `lp_superframe_packer`

## Requirements
- R1: Line sync stays high without a break for exactly 4*PIXELS transfers per line (2560 at the default). The first 2*PIXELS transfers are the colour section and the remaining 2*PIXELS are the raw section.
- R2: One frame holds LINES line-sync pulses. Frame sync rises FRONT_CYC cycles before the first line-sync rise. It falls BACK_CYC cycles after the last line-sync fall. Line sync is never high while frame sync is low.
- R3: Line sync stays low for HGAP_CYC cycles between lines of a frame. Frame sync stays low for VGAP_CYC cycles between frames.
- R4: Colour-section transfer k (counting from 0) belongs to pixel pair k/4, which covers pixels 2*(k/4) and 2*(k/4)+1. The value of k mod 4 selects the byte: 0 is Cb, 1 is the luma of the even pixel, 2 is Cr, and 3 is the luma of the odd pixel.
- R5: Each Cb and Cr byte equals (a+b+1)>>1 over the two 8-bit samples of the pair, computed without overflow, so 255 and 255 give 255.
- R6: Raw-section transfer j carries pixel j/2. An even j carries bits 7:0 of the raw word. An odd j carries bits 13:8 with the top two bits of the byte zero.
- R7: Each byte sits on bus bits 13:6 with its MSB on bit 13. Bits 5:0 are zero. The whole bus is zero while line sync is low.
- R8: The raw section of line n carries the words the raw port returns for line n. The caller feeds that port from the previous frame.
- R9: While reset is asserted, both syncs and the bus are zero. Frame sync first rises on the second clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-transfer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_line | output | 9 | Index of the line being read |
| rd_pair | output | 9 | Pixel-pair address for the colour ports |
| rd_pix | output | 10 | Pixel address for the raw port |
| pa_y | input | 8 | Luma of the even pixel of the pair |
| pa_cb | input | 8 | Cb of the even pixel |
| pa_cr | input | 8 | Cr of the even pixel |
| pb_y | input | 8 | Luma of the odd pixel of the pair |
| pb_cb | input | 8 | Cb of the odd pixel |
| pb_cr | input | 8 | Cr of the odd pixel |
| raw_word | input | 14 | Raw pre-gain word (previous frame) |
| vid_data | output | 14 | Byte bus, payload on bits 13:6 |
| vid_lsync | output | 1 | Line sync, active high |
| vid_fsync | output | 1 | Frame sync, active high |

## Verification
A state or counter error in the sequencer shows at the syncs within one line. A section boundary in the wrong place changes the length of the line-sync pulse. A wrong gap counter changes the number of low cycles before the next rise. A skipped transition to BACK changes the number of pulses in the frame. Errors in byte selection or rounding show one cycle after the bad read, as a wrong byte at a known transfer index. A wrong raw-byte phase swaps the halves of a word, which shows within two transfers of the section start.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRONT,
        ST_CSEC,
        ST_RSEC,
        ST_HGAP,
        ST_BACK,
        ST_VGAP
    } lp_state_t;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } lp_pix_t;

    localparam int LP_BYTE_W = 8;

endpackage

// File: rtl/lp_sequencer.sv
module lp_sequencer
    import lp_pkg::*;
#(
    parameter int PIXELS    = 640,
    parameter int LINES     = 480,
    parameter int FRONT_CYC = 4,
    parameter int HGAP_CYC  = 16,
    parameter int BACK_CYC  = 4,
    parameter int VGAP_CYC  = 64,
    parameter int DUR_W     = 16,
    localparam int SEG_W    = $clog2(2 * PIXELS),
    localparam int LINE_W   = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    output lp_state_t         state,
    output logic [SEG_W-1:0]  seg,
    output logic [LINE_W-1:0] line,
    output logic              lsync_en,
    output logic              fsync_en
);

    localparam logic [SEG_W-1:0]  SEG_LAST  = SEG_W'(2 * PIXELS - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

    lp_state_t         state_q, state_d;
    logic [SEG_W-1:0]  seg_q;
    logic [LINE_W-1:0] line_q;
    logic [DUR_W-1:0]  dur_q;
    logic [DUR_W-1:0]  dur_lim;
    logic              seg_last;
    logic              dur_done;
    logic              in_gap;

    assign seg_last = (seg_q == SEG_LAST);
    assign dur_done = (dur_q == dur_lim);

    always_comb begin
        dur_lim = '0;
        in_gap  = 1'b0;
        unique case (state_q)
            ST_FRONT: begin dur_lim = DUR_W'(FRONT_CYC - 1); in_gap = 1'b1; end
            ST_HGAP:  begin dur_lim = DUR_W'(HGAP_CYC - 1);  in_gap = 1'b1; end
            ST_BACK:  begin dur_lim = DUR_W'(BACK_CYC - 1);  in_gap = 1'b1; end
            ST_VGAP:  begin dur_lim = DUR_W'(VGAP_CYC - 1);  in_gap = 1'b1; end
            default:  begin dur_lim = '0; in_gap = 1'b0; end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_FRONT;
            ST_FRONT: if (dur_done) state_d = ST_CSEC;
            ST_CSEC:  if (seg_last) state_d = ST_RSEC;
            ST_RSEC:  if (seg_last) state_d = (line_q == LINE_LAST) ? ST_BACK : ST_HGAP;
            ST_HGAP:  if (dur_done) state_d = ST_CSEC;
            ST_BACK:  if (dur_done) state_d = ST_VGAP;
            ST_VGAP:  if (dur_done) state_d = ST_FRONT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transfer, line and gap counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q  <= '0;
            line_q <= '0;
            dur_q  <= '0;
        end else begin
            if ((state_q == ST_CSEC) || (state_q == ST_RSEC))
                seg_q <= seg_last ? '0 : seg_q + 1'b1;
            else
                seg_q <= '0;

            if (in_gap)
                dur_q <= dur_done ? '0 : dur_q + 1'b1;
            else
                dur_q <= '0;

            if ((state_q == ST_RSEC) && seg_last)
                line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        state    = state_q;
        seg      = seg_q;
        line     = line_q;
        lsync_en = (state_q == ST_CSEC) || (state_q == ST_RSEC);
        fsync_en = (state_q != ST_IDLE) && (state_q != ST_VGAP);
    end

    assert_csec_to_rsec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CSEC && seg_q == SEG_LAST) |=> (state_q == ST_RSEC && seg_q == '0));

    assert_last_line_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RSEC && seg_q == SEG_LAST && line_q == LINE_LAST) |=> (state_q == ST_BACK));

    assert_gap_to_csec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HGAP && $past(state_q) == ST_RSEC) |-> (line_q != '0));

endmodule

// File: rtl/lp_chroma_avg.sv
module lp_chroma_avg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] avg
);

    logic [W:0] sum;

    assign sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
    assign avg = sum[W:1];

    assert_avg_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((avg >= ((a < b) ? a : b)) && (avg <= ((a < b) ? b : a))));

endmodule

// File: rtl/lp_byte_mux.sv
module lp_byte_mux
    import lp_pkg::*;
#(
    parameter int PIXELS = 640,
    parameter int RAW_W  = 14,
    parameter int BUS_W  = 14,
    localparam int SEG_W = $clog2(2 * PIXELS),
    localparam int PAD_W = BUS_W - LP_BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lp_state_t        state,
    input  logic [SEG_W-1:0] seg,
    input  logic             lsync_en,
    input  logic             fsync_en,
    input  lp_pix_t          pix_even,
    input  lp_pix_t          pix_odd,
    input  logic [7:0]       cb_avg,
    input  logic [7:0]       cr_avg,
    input  logic [RAW_W-1:0] raw_word,
    output logic [BUS_W-1:0] vid_data,
    output logic             vid_lsync,
    output logic             vid_fsync
);

    logic [15:0] raw_ext;
    logic [7:0]  sel_byte;

    assign raw_ext = 16'(raw_word);

    always_comb begin
        sel_byte = '0;
        unique case (state)
            ST_CSEC: begin
                unique case (seg[1:0])
                    2'd0: sel_byte = cb_avg;
                    2'd1: sel_byte = pix_even.y;
                    2'd2: sel_byte = cr_avg;
                    2'd3: sel_byte = pix_odd.y;
                    default: sel_byte = '0;
                endcase
            end
            ST_RSEC: sel_byte = seg[0] ? raw_ext[15:8] : raw_ext[7:0];
            default: sel_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_data  <= '0;
            vid_lsync <= 1'b0;
            vid_fsync <= 1'b0;
        end else begin
            vid_data  <= lsync_en ? {sel_byte, {PAD_W{1'b0}}} : '0;
            vid_lsync <= lsync_en;
            vid_fsync <= fsync_en;
        end
    end

    assert_blank_bus_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_lsync |-> (vid_data == '0));

    assert_raw_high_top_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RSEC && seg[0]) |=> (vid_data[BUS_W-1 -: 2] == 2'b00));

endmodule

// File: rtl/lp_superframe_packer.sv
module lp_superframe_packer
    import lp_pkg::*;
#(
    parameter int PIXELS    = 640,
    parameter int LINES     = 480,
    parameter int FRONT_CYC = 4,
    parameter int HGAP_CYC  = 16,
    parameter int BACK_CYC  = 4,
    parameter int VGAP_CYC  = 64,
    parameter int RAW_W     = 14,
    parameter int BUS_W     = 14,
    localparam int SEG_W    = $clog2(2 * PIXELS),
    localparam int LINE_W   = $clog2(LINES),
    localparam int PAIR_W   = SEG_W - 2,
    localparam int PIX_W    = SEG_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LINE_W-1:0] rd_line,
    output logic [PAIR_W-1:0] rd_pair,
    output logic [PIX_W-1:0]  rd_pix,
    input  logic [7:0]        pa_y,
    input  logic [7:0]        pa_cb,
    input  logic [7:0]        pa_cr,
    input  logic [7:0]        pb_y,
    input  logic [7:0]        pb_cb,
    input  logic [7:0]        pb_cr,
    input  logic [RAW_W-1:0]  raw_word,
    output logic [BUS_W-1:0]  vid_data,
    output logic              vid_lsync,
    output logic              vid_fsync
);

    lp_state_t         state;
    logic [SEG_W-1:0]  seg;
    logic [LINE_W-1:0] line;
    logic              lsync_en;
    logic              fsync_en;
    lp_pix_t           pix_even;
    lp_pix_t           pix_odd;
    logic [7:0]        chroma_a   [2];
    logic [7:0]        chroma_b   [2];
    logic [7:0]        chroma_avg [2];

    lp_sequencer #(
        .PIXELS    (PIXELS),
        .LINES     (LINES),
        .FRONT_CYC (FRONT_CYC),
        .HGAP_CYC  (HGAP_CYC),
        .BACK_CYC  (BACK_CYC),
        .VGAP_CYC  (VGAP_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .seg      (seg),
        .line     (line),
        .lsync_en (lsync_en),
        .fsync_en (fsync_en)
    );

    assign rd_line  = line;
    assign rd_pair  = seg[SEG_W-1:2];
    assign rd_pix   = seg[SEG_W-1:1];
    assign pix_even = '{y: pa_y, cb: pa_cb, cr: pa_cr};
    assign pix_odd  = '{y: pb_y, cb: pb_cb, cr: pb_cr};

    assign chroma_a[0] = pix_even.cb;
    assign chroma_b[0] = pix_odd.cb;
    assign chroma_a[1] = pix_even.cr;
    assign chroma_b[1] = pix_odd.cr;

    for (genvar c = 0; c < 2; c++) begin : g_chroma
        lp_chroma_avg #(.W(8)) u_avg (
            .clk   (clk),
            .rst_n (rst_n),
            .a     (chroma_a[c]),
            .b     (chroma_b[c]),
            .avg   (chroma_avg[c])
        );
    end

    lp_byte_mux #(
        .PIXELS (PIXELS),
        .RAW_W  (RAW_W),
        .BUS_W  (BUS_W)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .seg       (seg),
        .lsync_en  (lsync_en),
        .fsync_en  (fsync_en),
        .pix_even  (pix_even),
        .pix_odd   (pix_odd),
        .cb_avg    (chroma_avg[0]),
        .cr_avg    (chroma_avg[1]),
        .raw_word  (raw_word),
        .vid_data  (vid_data),
        .vid_lsync (vid_lsync),
        .vid_fsync (vid_fsync)
    );

    assert_lsync_inside_fsync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vid_lsync |-> vid_fsync);

    assert_front_porch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_lsync) |-> $past(vid_fsync));

    assert_back_porch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vid_fsync) |-> !$past(vid_lsync));

endmodule

// File: tb/lp_superframe_packer_bench.sv
module lp_superframe_packer_bench;

    localparam int P  = 8;
    localparam int L  = 3;
    localparam int FR = 2;
    localparam int HB = 3;
    localparam int BK = 2;
    localparam int VB = 4;
    localparam int BUS_W = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]  rd_line;
    logic [1:0]  rd_pair;
    logic [2:0]  rd_pix;
    logic [7:0]  pa_y, pa_cb, pa_cr, pb_y, pb_cb, pb_cr;
    logic [13:0] raw_word;
    logic [BUS_W-1:0] vid_data;
    logic        vid_lsync, vid_fsync;

    int frame_ctr = 0;
    int n_chk = 0;
    int n_fail = 0;

    function automatic int f_y(int f, int l, int p);
        return (l * 37 + p * 11 + f * 5 + 3) % 256;
    endfunction
    function automatic int f_cb(int f, int l, int p);
        if (p < 2) return 255;
        return (l * 13 + p * 29 + f) % 256;
    endfunction
    function automatic int f_cr(int f, int l, int p);
        if (p == 0) return 0;
        if (p == 1) return 1;
        return (p * 71 + l * 3 + f * 19 + 91) % 256;
    endfunction
    function automatic int f_raw(int f, int l, int p);
        if (p == P - 1) return 16383;
        return (l * 1021 + p * 317 + f * 4093 + 7) % 16384;
    endfunction

    // caller model: colour from current frame, raw from the previous frame
    assign pa_y     = 8'(f_y (frame_ctr, int'(rd_line), 2 * int'(rd_pair)));
    assign pa_cb    = 8'(f_cb(frame_ctr, int'(rd_line), 2 * int'(rd_pair)));
    assign pa_cr    = 8'(f_cr(frame_ctr, int'(rd_line), 2 * int'(rd_pair)));
    assign pb_y     = 8'(f_y (frame_ctr, int'(rd_line), 2 * int'(rd_pair) + 1));
    assign pb_cb    = 8'(f_cb(frame_ctr, int'(rd_line), 2 * int'(rd_pair) + 1));
    assign pb_cr    = 8'(f_cr(frame_ctr, int'(rd_line), 2 * int'(rd_pair) + 1));
    assign raw_word = 14'(f_raw(frame_ctr - 1, int'(rd_line), int'(rd_pix)));

    always @(posedge vid_fsync) frame_ctr = frame_ctr + 1;

    lp_superframe_packer #(
        .PIXELS (P), .LINES (L), .FRONT_CYC (FR), .HGAP_CYC (HB),
        .BACK_CYC (BK), .VGAP_CYC (VB)
    ) u_lp_superframe_packer (
        .clk (clk), .rst_n (rst_n),
        .rd_line (rd_line), .rd_pair (rd_pair), .rd_pix (rd_pix),
        .pa_y (pa_y), .pa_cb (pa_cb), .pa_cr (pa_cr),
        .pb_y (pb_y), .pb_cb (pb_cb), .pb_cr (pb_cr),
        .raw_word (raw_word),
        .vid_data (vid_data), .vid_lsync (vid_lsync), .vid_fsync (vid_fsync)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_byte(int f, int l, int k);
        int pr, j;
        if (k < 2 * P) begin
            pr = k / 4;
            case (k % 4)
                0: return (f_cb(f, l, 2 * pr) + f_cb(f, l, 2 * pr + 1) + 1) / 2;
                1: return f_y(f, l, 2 * pr);
                2: return (f_cr(f, l, 2 * pr) + f_cr(f, l, 2 * pr + 1) + 1) / 2;
                default: return f_y(f, l, 2 * pr + 1);
            endcase
        end
        j = k - 2 * P;
        if (j % 2 == 0) return f_raw(f - 1, l, j / 2) % 256;
        return f_raw(f - 1, l, j / 2) / 256;
    endfunction

    bit mon_on = 1'b0;
    bit pl = 1'b0, pf = 1'b0, seen_fall = 1'b0;
    int lo_l = 0, lo_f = 0, byte_k = 0, line_in = 0, frames_done = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (vid_fsync && !pf) begin
                if (seen_fall) chk(lo_f == VB, "R3 vgap", lo_f, VB);
                line_in = 0;
                lo_l = 0;
            end
            if (!vid_fsync) begin
                if (pf) begin
                    chk(lo_l == BK, "R2 back porch", lo_l, BK);
                    chk(line_in == L, "R2 lines per frame", line_in, L);
                    frames_done++;
                    seen_fall = 1'b1;
                    lo_f = 0;
                end
                lo_f++;
                chk(!vid_lsync, "R2 lsync outside fsync", int'(vid_lsync), 0);
            end else begin
                if (vid_lsync && !pl) begin
                    if (line_in == 0) chk(lo_l == FR, "R2 front porch", lo_l, FR);
                    else              chk(lo_l == HB, "R3 hgap", lo_l, HB);
                    byte_k = 0;
                end
                if (vid_lsync) begin
                    int e;
                    e = exp_byte(frame_ctr, line_in, byte_k);
                    if (byte_k >= 2 * P)          // R8: raw from same line, previous frame
                        chk(int'(vid_data) == e * 64,
                            (byte_k % 2 == 0) ? "R8 raw low byte" : "R6 raw high byte",
                            int'(vid_data), e * 64);
                    else if (byte_k % 2 == 0)
                        chk(int'(vid_data) == e * 64, "R5 chroma", int'(vid_data), e * 64);
                    else
                        chk(int'(vid_data) == e * 64, "R4 luma", int'(vid_data), e * 64);
                    chk(vid_data[5:0] == 6'd0, "R7 low bits", int'(vid_data[5:0]), 0);
                    byte_k++;
                    lo_l = 0;
                end else begin
                    if (pl) begin
                        chk(byte_k == 4 * P, "R1 line length", byte_k, 4 * P);
                        line_in++;
                    end
                    lo_l++;
                    chk(vid_data == '0, "R7 blank bus", int'(vid_data), 0);
                end
            end
            pl = vid_lsync;
            pf = vid_fsync;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(vid_data == '0 && !vid_lsync && !vid_fsync, "R9 reset outputs",
                int'({vid_lsync, vid_fsync}), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(!vid_fsync, "R9 fsync after first edge", int'(vid_fsync), 0);
        @(negedge clk);
        chk(vid_fsync, "R9 fsync after second edge", int'(vid_fsync), 1);
        pf = 1'b0;
        pl = 1'b0;
        mon_on = 1'b1;
        lo_l = 0;
        // first sample of the monitor sees the rise; seed the front-porch count
        begin : run
            int cyc;
            cyc = 0;
            while (frames_done < 3 && cyc < 20000) begin
                @(negedge clk);
                cyc++;
            end
            if (frames_done < 3) chk(1'b0, "watchdog", frames_done, 3);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule